// File: doc/BRIEF.md
# Decoder Open-Fault Pair Tester

This block is a self-contained test engine for a single-port synchronous RAM of up to 64K words. It targets stuck-open defects in the RAM's address decoder. Such a defect leaves a decoder output floating, so the output keeps whatever charge the previous access left on it. A plain linear march rarely exposes it, because the fault only shows when two addresses that differ in one bit are used on consecutive cycles, and the victim's node has first been driven to the opposite state.

Once started, the engine owns the RAM port. It takes the enabled address bits in ascending order. For each bit it takes every base address of the programmed range in ascending order, and each base address is the victim. For each victim it issues three gapless accesses: write all ones to the victim, write all zeros to the aggressor (the victim with the chosen bit flipped), then read the victim back. Every read word is folded into a 16-bit MISR. The read can also be compared against all ones; the first mismatch raises a sticky fail flag and records the victim address.

Bits that other memory tests already cover can be left out of the enable mask. Bits at or above the programmed address width are skipped automatically.

Top module: `dec_open_tester`

## Requirements
- R1: After reset, busy, done and fail are low, the signature reads 16'hFFFF and the RAM enable is low.
- R2: Each element is three RAM accesses on consecutive cycles, in this order: write of all-ones data to the victim, write of all-zeros data to the aggressor, read of the victim.
- R3: The aggressor address equals the victim address with exactly the selected bit inverted (Hamming distance 1).
- R4: Bits are taken in ascending order over the enabled mask bits below the programmed address width; mask bits at or above that width are ignored. For each bit, victims run in ascending order from the low base to the high base, both inclusive.
- R5: The RAM enable stays high on every cycle from the first access of a run to its last; there is no idle cycle between elements.
- R6: At start the signature is set to 16'hFFFF. Each read word d, zero-extended to 16 bits, updates it in read order to (s<<1) ^ (s[15] ? 16'h100B : 0) ^ d, which is the polynomial x^16+x^12+x^3+x+1.
- R7: With compare enabled at start, the first read that is not all ones sets fail and stores its victim in fail_addr. Later mismatches change neither. With compare disabled, fail stays low.
- R8: Done is high for exactly one cycle, with busy low in that cycle. For N elements, done is high 3N+3 cycles after the start edge (counting the start edge as 1). With no usable bit, it is high 1 cycle after the start edge.
- R9: A start pulse while busy is ignored; the run's length and accesses are unchanged.
- R10: If the high base is below the low base, only the low base is tested for each bit.
- R11: After done, fail, fail_addr and the signature hold until the next start. An accepted start clears fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| bit_mask | input | AW | Address bits to exercise |
| addr_bits | input | $clog2(AW+1) | Number of usable address bits |
| base_lo | input | AW | First victim address |
| base_hi | input | AW | Last victim address |
| cmp_en | input | 1 | Enable compare of read data against all ones |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Victim of the first mismatch |
| signature | output | 16 | MISR over all read words |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after the read |

## Verification
The bench builds the block with AW=8 and DW=8. An 8-bit data word exercises the zero-extending fold into the signature, and 256 words let a full RAM model sit in the bench. That model includes an injectable decoder open: a read of a victim that directly follows an access to its one-bit neighbour returns the neighbour's data. This makes it possible to check single and repeated mismatches, the first-fail capture and the signature with compare both on and off. The small width also brings the address-width cut-off and reversed or single-entry base ranges within a few hundred cycles.

// File: rtl/dot_pkg.sv
package dot_pkg;
   localparam int SIG_W = 16;
   localparam logic [SIG_W-1:0] SIG_POLY = 16'h100B;
   localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WVIC,
      ST_WAGG,
      ST_RVIC,
      ST_DRN1,
      ST_DRN2,
      ST_FIN
   } dot_state_e;
endpackage

// File: rtl/dot_bit_picker.sv
module dot_bit_picker #(
   parameter int AW = 16,
   parameter int BW = $clog2(AW)
) (
   input  logic [AW-1:0] mask,
   input  logic [BW-1:0] cur,
   input  logic          from_start,
   output logic          found,
   output logic [BW-1:0] idx
);
   // Lowest enabled bit strictly above cur (or lowest overall on a fresh start).
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = AW - 1; i >= 0; i--) begin
         if (mask[i] && (from_start || i > int'(cur))) begin
            found = 1'b1;
            idx   = BW'(i);
         end
      end
   end
endmodule

// File: rtl/dot_misr.sv
module dot_misr
   import dot_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed,
   input  logic             en,
   input  logic [DW-1:0]    din,
   output logic [SIG_W-1:0] sig
);
   logic [SIG_W-1:0] fold;

   generate
      if (DW == SIG_W) begin : g_same
         assign fold = din;
      end else if (DW < SIG_W) begin : g_ext
         assign fold = {{(SIG_W - DW){1'b0}}, din};
      end else begin : g_xor
         always_comb begin
            fold = '0;
            for (int i = 0; i < DW; i++) begin
               fold[i % SIG_W] = fold[i % SIG_W] ^ din[i];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig <= SIG_SEED;
      end else if (seed) begin
         sig <= SIG_SEED;
      end else if (en) begin
         sig <= {sig[SIG_W-2:0], 1'b0} ^ (sig[SIG_W-1] ? SIG_POLY : '0) ^ fold;
      end
   end
endmodule

// File: rtl/dot_resp.sv
module dot_resp #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          rd_issue,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] ram_rdata,
   input  logic          cmp_on,
   output logic          cap_vld,
   output logic [DW-1:0] cap_data,
   output logic          fail,
   output logic [AW-1:0] fail_addr
);
   logic          pend;
   logic [AW-1:0] pend_addr;
   logic [AW-1:0] cap_addr;
   logic          mismatch;

   // Stage 1: read issued; stage 2: RAM data valid and registered.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_addr <= '0;
         cap_vld   <= 1'b0;
         cap_data  <= '0;
         cap_addr  <= '0;
      end else if (clear) begin
         pend    <= 1'b0;
         cap_vld <= 1'b0;
      end else begin
         pend    <= rd_issue;
         cap_vld <= pend;
         if (rd_issue) pend_addr <= rd_addr;
         if (pend) begin
            cap_data <= ram_rdata;
            cap_addr <= pend_addr;
         end
      end
   end

   assign mismatch = cap_vld && cmp_on && (cap_data != {DW{1'b1}});

   // Stage 3: compare registered data, keep only the first failure.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail      <= 1'b0;
         fail_addr <= '0;
      end else if (clear) begin
         fail      <= 1'b0;
         fail_addr <= '0;
      end else if (mismatch && !fail) begin
         fail      <= 1'b1;
         fail_addr <= cap_addr;
      end
   end
endmodule

// File: rtl/dec_open_tester.sv
module dec_open_tester
   import dot_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [AW-1:0]            bit_mask,
   input  logic [$clog2(AW+1)-1:0]  addr_bits,
   input  logic [AW-1:0]            base_lo,
   input  logic [AW-1:0]            base_hi,
   input  logic                     cmp_en,
   output logic                     busy,
   output logic                     done,
   output logic                     fail,
   output logic [AW-1:0]            fail_addr,
   output logic [15:0]              signature,
   output logic                     ram_en,
   output logic                     ram_we,
   output logic [AW-1:0]            ram_addr,
   output logic [DW-1:0]            ram_wdata,
   input  logic [DW-1:0]            ram_rdata
);
   localparam int IW = $clog2(AW + 1);
   localparam int BW = $clog2(AW);

   generate
      if (AW < 2 || AW > 16) begin : g_bad_aw
         $error("dec_open_tester: AW must lie in 2..16");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dec_open_tester: DW must be at least 1");
      end
   endgenerate

   dot_state_e    state;
   logic [AW-1:0] amask;
   logic [AW-1:0] eff_mask;
   logic [AW-1:0] mask_q, amask_q, lo_q, hi_q;
   logic          cmp_q;
   logic [BW-1:0] cur_bit;
   logic [AW-1:0] base;
   logic [AW-1:0] victim, aggressor;
   logic          take;
   logic          pick_found;
   logic [BW-1:0] pick_idx;
   logic          cap_vld;
   logic [DW-1:0] cap_data;

   // Usable-width mask from the programmed address width.
   generate
      for (genvar g = 0; g < AW; g++) begin : g_amask
         assign amask[g] = (IW'(g) < addr_bits);
      end
   endgenerate

   assign eff_mask = bit_mask & amask;
   assign take     = start && (state == ST_IDLE);

   dot_bit_picker #(.AW(AW), .BW(BW)) u_pick (
      .mask       ((state == ST_IDLE) ? eff_mask : mask_q),
      .cur        (cur_bit),
      .from_start (state == ST_IDLE),
      .found      (pick_found),
      .idx        (pick_idx)
   );

   assign victim    = base & amask_q;
   assign aggressor = victim ^ (AW'(1) << cur_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         mask_q  <= '0;
         amask_q <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         cmp_q   <= 1'b0;
         cur_bit <= '0;
         base    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take) begin
                  mask_q  <= eff_mask;
                  amask_q <= amask;
                  lo_q    <= base_lo;
                  hi_q    <= base_hi;
                  cmp_q   <= cmp_en;
                  cur_bit <= pick_idx;
                  base    <= base_lo;
                  state   <= pick_found ? ST_WVIC : ST_FIN;
               end
            end
            ST_WVIC: state <= ST_WAGG;
            ST_WAGG: state <= ST_RVIC;
            ST_RVIC: begin
               if (base < hi_q) begin
                  base  <= base + AW'(1);
                  state <= ST_WVIC;
               end else if (pick_found) begin
                  cur_bit <= pick_idx;
                  base    <= lo_q;
                  state   <= ST_WVIC;
               end else begin
                  state <= ST_DRN1;
               end
            end
            ST_DRN1: state <= ST_DRN2;
            ST_DRN2: state <= ST_FIN;
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // RAM port drive: one access per element cycle, nothing otherwise.
   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = '0;
      ram_wdata = '0;
      unique case (state)
         ST_WVIC: begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = victim;
            ram_wdata = {DW{1'b1}};
         end
         ST_WAGG: begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = aggressor;
         end
         ST_RVIC: begin
            ram_en    = 1'b1;
            ram_addr  = victim;
         end
         default: ;
      endcase
   end

   dot_resp #(.AW(AW), .DW(DW)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (take),
      .rd_issue  (state == ST_RVIC),
      .rd_addr   (victim),
      .ram_rdata (ram_rdata),
      .cmp_on    (cmp_q),
      .cap_vld   (cap_vld),
      .cap_data  (cap_data),
      .fail      (fail),
      .fail_addr (fail_addr)
   );

   dot_misr #(.DW(DW)) u_misr (
      .clk   (clk),
      .rst_n (rst_n),
      .seed  (take),
      .en    (cap_vld),
      .din   (cap_data),
      .sig   (signature)
   );

   assign busy = (state != ST_IDLE) && (state != ST_FIN);
   assign done = (state == ST_FIN);
endmodule

// File: rtl/dot_checker.sv
module dot_checker #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          fail,
   input logic [AW-1:0] fail_addr,
   input logic          ram_en,
   input logic          ram_we,
   input logic [AW-1:0] ram_addr,
   input logic [DW-1:0] ram_wdata
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ram_en);

   assert_hamming_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we && ram_wdata == {DW{1'b1}}) |=>
      (ram_en && ram_we && ram_wdata == {DW{1'b0}} &&
       $countones(ram_addr ^ $past(ram_addr)) == 1));

   assert_read_victim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we && ram_wdata == {DW{1'b0}}) |=>
      (ram_en && !ram_we && ram_addr == $past(ram_addr, 2)));

   assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we) |=> ram_en);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> (fail && $stable(fail_addr)));
endmodule

bind dec_open_tester dot_checker #(.AW(AW), .DW(DW)) u_dot_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .fail      (fail),
   .fail_addr (fail_addr),
   .ram_en    (ram_en),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .ram_wdata (ram_wdata)
);

// File: tb/tb_dec_open_tester.sv
`timescale 1ns/1ps
module tb_dec_open_tester;
   localparam int AW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] bit_mask = '0;
   logic [3:0]    addr_bits = '0;
   logic [AW-1:0] base_lo = '0, base_hi = '0;
   logic          cmp_en = 1'b0;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr;
   logic [15:0]   signature;
   logic          ram_en, ram_we;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata = '0;

   always #10 clk = ~clk;

   dec_open_tester #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .bit_mask(bit_mask),
      .addr_bits(addr_bits), .base_lo(base_lo), .base_hi(base_hi),
      .cmp_en(cmp_en), .busy(busy), .done(done), .fail(fail),
      .fail_addr(fail_addr), .signature(signature), .ram_en(ram_en),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata)
   );

   // RAM model with an optional decoder open on bit f_bit for victims f_lo..f_hi.
   logic [DW-1:0] mem [256];
   logic [AW-1:0] prev_addr = '0;
   logic          prev_vld = 1'b0;
   bit            f_on = 0;
   int            f_bit = 0, f_lo = 0, f_hi = 0;
   int            cyc = 0;
   logic          log_we [512];
   logic [AW-1:0] log_addr [512];
   logic [DW-1:0] log_data [512];
   int            log_cyc [512];
   int            log_n = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (ram_en) begin
         if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
         end else if (f_on && prev_vld && int'(ram_addr) >= f_lo && int'(ram_addr) <= f_hi &&
                      prev_addr == (ram_addr ^ AW'(1 << f_bit))) begin
            ram_rdata <= mem[prev_addr];
         end else begin
            ram_rdata <= mem[ram_addr];
         end
         if (log_n < 512) begin
            log_we[log_n]   <= ram_we;
            log_addr[log_n] <= ram_addr;
            log_data[log_n] <= ram_wdata;
            log_cyc[log_n]  <= cyc;
            log_n           <= log_n + 1;
         end
         prev_addr <= ram_addr;
         prev_vld  <= 1'b1;
      end else begin
         prev_vld <= 1'b0;
      end
   end

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] misr_step(input logic [15:0] s, input logic [DW-1:0] d);
      return {s[14:0], 1'b0} ^ (s[15] ? 16'h100B : 16'h0) ^ {8'h00, d};
   endfunction

   // Expected element list and results.
   int            e_n;
   logic [AW-1:0] e_vic [256];
   int            e_bit [256];
   logic [15:0]   e_sig;
   bit            e_fail;
   logic [AW-1:0] e_faddr;
   int            run_cycles;

   task automatic plan(input int abits, input logic [AW-1:0] m, input int lo, input int hi, input bit cmp);
      e_n = 0; e_sig = 16'hFFFF; e_fail = 0; e_faddr = '0;
      for (int b = 0; b < AW; b++) begin
         if (m[b] && b < abits) begin
            for (int v = lo; ; v++) begin
               logic [DW-1:0] rd;
               e_vic[e_n] = AW'(v);
               e_bit[e_n] = b;
               e_n++;
               rd = (f_on && b == f_bit && v >= f_lo && v <= f_hi) ? 8'h00 : 8'hFF;
               e_sig = misr_step(e_sig, rd);
               if (cmp && rd != 8'hFF && !e_fail) begin
                  e_fail = 1; e_faddr = AW'(v);
               end
               if (v >= hi) break;
            end
         end
      end
   endtask

   task automatic run(input int abits, input logic [AW-1:0] m, input int lo, input int hi,
                      input bit cmp, input bit poke);
      @(negedge clk);
      addr_bits = 4'(abits); bit_mask = m; base_lo = AW'(lo); base_hi = AW'(hi); cmp_en = cmp;
      log_n = 0;
      plan(abits, m, lo, hi, cmp);
      start = 1'b1;
      @(posedge clk);
      run_cycles = 1;
      @(negedge clk);
      start = 1'b0;
      while (!done && run_cycles < 3000) begin
         @(posedge clk);
         run_cycles++;
         @(negedge clk);
         start = poke && (run_cycles == 4);
      end
      start = 1'b0;
   endtask

   task automatic check_run(input string tag);
      int exp_cyc;
      int bad;
      exp_cyc = (e_n == 0) ? 1 : 3 * e_n + 3;
      chk(run_cycles == exp_cyc, {tag, " R8 done timing"}, run_cycles, exp_cyc);
      chk(done && !busy, {tag, " R8 done with busy low"}, {busy, done}, 1);
      chk(log_n == 3 * e_n, {tag, " R4 access count"}, log_n, 3 * e_n);
      bad = 0;
      for (int k = 0; k < e_n && 3 * k + 2 < log_n; k++) begin
         logic [AW-1:0] v;
         v = e_vic[k];
         if (!(log_we[3*k] && log_addr[3*k] == v && log_data[3*k] == 8'hFF)) bad++;
         if (!(log_we[3*k+1] && log_data[3*k+1] == 8'h00)) bad++;
         if (log_addr[3*k+1] != (v ^ AW'(1 << e_bit[k]))) bad++;
         if (!(!log_we[3*k+2] && log_addr[3*k+2] == v)) bad++;
      end
      chk(bad == 0, {tag, " R2 R3 R4 element order and pairs"}, bad, 0);
      if (e_n > 0)
         chk(log_cyc[log_n-1] - log_cyc[0] == log_n - 1, {tag, " R5 gapless accesses"},
             log_cyc[log_n-1] - log_cyc[0], log_n - 1);
      chk(signature == e_sig, {tag, " R6 signature"}, signature, e_sig);
      chk(fail == e_fail, {tag, " R7 fail flag"}, fail, e_fail);
      if (e_fail) chk(fail_addr == e_faddr, {tag, " R7 fail address"}, fail_addr, e_faddr);
      @(negedge clk);
      chk(!done && !busy, {tag, " R8 single done pulse"}, {busy, done}, 0);
   endtask

   task automatic t_reset;
      chk(!busy && !done && !fail, "R1 reset flags", {busy, done, fail}, 0);
      chk(signature == 16'hFFFF, "R1 reset signature", signature, 16'hFFFF);
      chk(!ram_en, "R1 reset ram idle", ram_en, 0);
   endtask

   task automatic t_basic;
      f_on = 0;
      run(8, 8'b0000_0101, 3, 5, 1, 0);
      check_run("basic");
   endtask

   task automatic t_fault;
      f_on = 1; f_bit = 2; f_lo = 5; f_hi = 6;
      run(8, 8'h86, 4, 6, 1, 0);
      check_run("fault cmp");
      run(8, 8'h86, 4, 6, 0, 0);
      check_run("fault nocmp R7");
      f_on = 0;
   endtask

   task automatic t_width;
      run(3, 8'hFF, 0, 7, 1, 0);
      check_run("width R4");
      run(4, 8'hF0, 0, 3, 1, 0);
      check_run("empty R8");
   endtask

   task automatic t_reverse;
      run(8, 8'h12, 9, 2, 1, 0);
      check_run("reverse R10");
   endtask

   task automatic t_busy_start;
      run(8, 8'h03, 0, 4, 1, 1);
      check_run("start while busy R9");
   endtask

   task automatic t_hold;
      logic [15:0]   s;
      logic [AW-1:0] fa;
      f_on = 1; f_bit = 1; f_lo = 0; f_hi = 0;
      run(8, 8'h02, 0, 1, 1, 0);
      check_run("hold setup");
      s = signature; fa = fail_addr;
      repeat (5) @(negedge clk);
      chk(fail && signature == s && fail_addr == fa, "R11 results hold", {fail, signature}, {1'b1, s});
      f_on = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!fail && busy, "R11 start clears fail", {fail, busy}, 1);
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_fault();
      t_width();
      t_reverse();
      t_busy_start();
      t_hold();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule